// File: doc/BRIEF.md
# Nibble-Serial Debug Memory Monitor

This block is a debug-port slave that lets an external host read and write the memory space of a chip through four data lines and one active-low framing strobe. The host lowers the strobe and sends a request one nibble per clock. The port turns each accepted request into a single transfer on a simple request/acknowledge memory bus. It then reports progress on the same four lines: a not-ready code while the transfer is in flight, and a ready code when it ends, with flag bits for a rejected command and for a bus fault.

For a read, the host waits until it sees ready and then raises the strobe. The port then returns the data nibble by nibble, least significant first. The port stays silent unless the monitor-mode input was high in the last cycle of the monitor reset. Pad tristate control lives outside the block, so the four-line port appears here as separate input, output and output-enable signals.

Top module: `nib_dbg_monitor`

## Requirements
- R1: The port is active only if `mode_sel` was high in the last clock cycle in which `mon_rst_n` was low. Otherwise it never raises `nib_oe` or `mem_req`, and later changes of `mode_sel` have no effect until the next reset.
- R2: A frame starts in the first cycle with `sync_n` low. The first nibble is a spare field, and the second is the command: bit 3 must be 1, bit 2 selects write (1) or read (0), and bits 1:0 select the size (00 byte, 01 16-bit, 10 32-bit). The command's direction and size appear on `mem_we` and `mem_size`.
- R3: The eight nibbles after the command form the address, least significant nibble first, and appear unchanged on `mem_addr`.
- R4: A valid write command is followed by 2, 4 or 8 data nibbles for byte, 16-bit or 32-bit, least significant first. They appear right-aligned on `mem_wdata`, with the upper bits zero.
- R5: One clock after the last request nibble, `mem_req` rises and stays high with a stable address and data until a cycle with `mem_ack` or `mem_err`. While `mem_req` is high, the port drives 0000.
- R6: After an acknowledged transfer, the port drives 0001 from the next cycle on, for as long as `sync_n` stays low.
- R7: For a read, the first clock edge that samples `sync_n` high during the ready status starts the return of data. From the next cycle, the port drives the low 2, 4 or 8 nibbles of `mem_rdata`, least significant first, one per clock. It then releases the bus.
- R8: A command nibble with bit 3 clear, a size code of 11, or a spare nibble other than 0000 is a command error. The port absorbs the eight address nibbles, expects no data nibbles, makes no bus request, and then drives 0011.
- R9: If a transfer ends with `mem_err`, the port drives 0101 and returns no read data. `mem_err` wins over `mem_ack` in the same cycle.
- R10: Raising `sync_n` before a request is complete abandons the frame without any bus request or output drive, and the next frame is accepted normally.
- R11: `nib_oe` is high only while the port drives not-ready, a final status or read data. It is low after reset and once the status or data has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mon_rst_n | input | 1 | Synchronous active-low monitor reset |
| mode_sel | input | 1 | Monitor mode select, captured during reset |
| sync_n | input | 1 | Active-low frame strobe from the host |
| nib_in | input | 4 | Nibble from the host |
| nib_out | output | 4 | Status or read-data nibble to the host |
| nib_oe | output | 1 | Output enable for the nibble pads |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_size | output | 2 | Transfer size: 00 byte, 01 16-bit, 10 32-bit |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_ack | input | 1 | Transfer completed |
| mem_err | input | 1 | Transfer ended with a bus fault |
| mem_rdata | input | 32 | Right-aligned read data |

## Verification
Wrong internal state shows up on the ports within a clock or two. A bad nibble count leaves the port expecting data while the host polls, so the expected 0000 or status nibble is missing in the first poll cycle. A wrong nibble index corrupts `mem_addr` or `mem_wdata` at the first cycle of `mem_req`, or corrupts a returned data nibble at its exact cycle. A stale error flag alters the status nibble in the cycle after the transfer ends. A stuck state leaves `nib_oe` high one cycle after the return should have finished. The bench sweeps all sixteen command nibbles, varies the acknowledge latency, and includes a faulting address range, so every size, direction and rejection path is exercised.

// File: rtl/nib_dbg_monitor.sv
module nib_dbg_monitor #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              mon_rst_n,
  input  logic              mode_sel,
  input  logic              sync_n,
  input  logic [3:0]        nib_in,
  output logic [3:0]        nib_out,
  output logic              nib_oe,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata
);
  localparam int ADDR_N = ADDR_W / 4;
  localparam int CW = (ADDR_N > 8) ? $clog2(ADDR_N) : 3;

  typedef enum logic [2:0] {IDLE, CMD, ADR, WDAT, BUSY, DONE, SEND} st_t;

  st_t              st;
  logic             mon_en, spare_bad, dir, cerr, berr;
  logic [1:0]       sz;
  logic [CW-1:0]    cnt;
  logic [ADDR_W-1:0] addr;
  logic [31:0]      dat;
  logic [2:0]       last_idx;
  logic             end_addr, end_dat;

  assign last_idx = {sz[1], sz[1] | sz[0], 1'b1};
  assign end_addr = cnt == CW'(ADDR_N - 1);
  assign end_dat  = cnt == CW'(last_idx);

  assign mem_req   = st == BUSY;
  assign mem_we    = dir;
  assign mem_size  = sz;
  assign mem_addr  = addr;
  assign mem_wdata = dat;
  assign nib_oe    = st inside {BUSY, DONE, SEND};
  assign nib_out   = (st == DONE) ? {1'b0, berr, cerr, 1'b1} :
                     (st == SEND) ? dat[{cnt[2:0], 2'b00} +: 4] : 4'h0;

  always_ff @(posedge clk)
    if (!mon_rst_n) mon_en <= mode_sel;

  always_ff @(posedge clk) begin
    if (!mon_rst_n) begin
      st        <= IDLE;
      spare_bad <= 1'b0;
      dir       <= 1'b0;
      sz        <= 2'b00;
      cerr      <= 1'b0;
      berr      <= 1'b0;
      cnt       <= '0;
      addr      <= '0;
      dat       <= '0;
    end else begin
      case (st)
        IDLE: begin
          cerr <= 1'b0;
          berr <= 1'b0;
          cnt  <= '0;
          if (mon_en && !sync_n) begin
            spare_bad <= |nib_in;
            st        <= CMD;
          end
        end
        CMD:
          if (sync_n) st <= IDLE;
          else begin
            dir  <= nib_in[2];
            sz   <= nib_in[1:0];
            cerr <= spare_bad | ~nib_in[3] | (&nib_in[1:0]);
            st   <= ADR;
          end
        ADR:
          if (sync_n) st <= IDLE;
          else begin
            addr[{cnt, 2'b00} +: 4] <= nib_in;
            cnt <= cnt + CW'(1);
            if (end_addr) begin
              cnt <= '0;
              dat <= '0;
              st  <= cerr ? DONE : (dir ? WDAT : BUSY);
            end
          end
        WDAT:
          if (sync_n) st <= IDLE;
          else begin
            dat[{cnt[2:0], 2'b00} +: 4] <= nib_in;
            cnt <= cnt + CW'(1);
            if (end_dat) begin
              cnt <= '0;
              st  <= BUSY;
            end
          end
        BUSY:
          if (mem_ack || mem_err) begin
            berr <= mem_err;
            if (!dir) dat <= mem_rdata;
            st <= DONE;
          end
        DONE:
          if (sync_n) begin
            cnt <= '0;
            st  <= (!dir && !cerr && !berr) ? SEND : IDLE;
          end
        SEND: begin
          cnt <= cnt + CW'(1);
          if (end_dat) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_mode_off_r1: assert property (@(posedge clk) disable iff (!mon_rst_n)
    !mon_en |-> !nib_oe && !mem_req);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!mon_rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  p_busy_nib_r5: assert property (@(posedge clk) disable iff (!mon_rst_n)
    mem_req |-> nib_oe && nib_out == 4'h0);

  p_ready_r6: assert property (@(posedge clk) disable iff (!mon_rst_n)
    $fell(mem_req) |-> nib_oe && nib_out[0] && !nib_out[1]);

  p_no_req_cerr_r8: assert property (@(posedge clk) disable iff (!mon_rst_n)
    cerr |-> !mem_req);

  p_berr_stat_r9: assert property (@(posedge clk) disable iff (!mon_rst_n)
    $fell(mem_req) && $past(mem_err) |-> nib_out == 4'b0101);
endmodule

// File: tb/sim_nib_dbg_monitor.sv
module sim_nib_dbg_monitor;
  logic        clk = 1'b0;
  logic        mon_rst_n = 1'b0, mode_sel = 1'b0, sync_n = 1'b1;
  logic [3:0]  nib_in = 4'h0, nib_out;
  logic        nib_oe, mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  nib_dbg_monitor #(.ADDR_W(32)) u0 (
    .clk(clk), .mon_rst_n(mon_rst_n), .mode_sel(mode_sel), .sync_n(sync_n),
    .nib_in(nib_in), .nib_out(nib_out), .nib_oe(nib_oe),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rfun(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h3C5A_96E1 ^ (a << 3);
  endfunction

  function automatic logic [31:0] nmask(input int n);
    return (n >= 8) ? 32'hFFFF_FFFF : ((32'h1 << (4 * n)) - 32'h1);
  endfunction

  task automatic send_head(input logic [3:0] spare, input logic [3:0] cmd);
    @(negedge clk); sync_n = 1'b0; nib_in = spare;
    @(negedge clk); nib_in = cmd;
  endtask

  task automatic run(input logic [3:0] spare, input logic [3:0] cmd,
                     input logic [31:0] a, input logic [31:0] wd, input int lat);
    logic valid, we, be;
    logic [3:0] sexp;
    logic [31:0] rexp, wexp;
    int n, seen;
    bit got;
    valid = (spare == 4'h0) && cmd[3] && (cmd[1:0] != 2'b11);
    we    = cmd[2];
    n     = 2 << cmd[1:0];
    be    = valid && (a[31:28] == 4'hE);
    wexp  = wd & nmask(n);
    rexp  = rfun(a);
    sexp  = !valid ? 4'b0011 : (be ? 4'b0101 : 4'b0001);
    send_head(spare, cmd);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); nib_in = a[i*4 +: 4];
    end
    if (valid && we)
      for (int i = 0; i < n; i++) begin
        @(negedge clk); nib_in = wd[i*4 +: 4];
      end
    seen = 0;
    got = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      nib_in = 4'h0;
      if (nib_oe && nib_out != 4'h0) got = 1'b1;
      else begin
        chk(nib_oe && nib_out == 4'h0 && mem_req, "R5 not-ready while busy", {27'd0, mem_req, nib_out}, 32'h10);
        if (mem_req) begin
          seen++;
          chk(mem_addr == a, "R3 address", mem_addr, a);
          chk(mem_we == we, "R2 direction", {31'd0, mem_we}, {31'd0, we});
          chk(mem_size == cmd[1:0], "R2 size", {30'd0, mem_size}, {30'd0, cmd[1:0]});
          if (we) chk(mem_wdata == wexp, "R4 write data", mem_wdata, wexp);
          mem_rdata = rexp;
          mem_ack = (seen > lat) && !be;
          mem_err = (seen > lat) && be;
        end
      end
    end
    mem_ack = 1'b0;
    mem_err = 1'b0;
    chk(got, "R6 status appears", {31'd0, got}, 32'd1);
    chk(nib_out == sexp, valid ? (be ? "R9 bus error status" : "R6 ready status") : "R8 command error status",
        {28'd0, nib_out}, {28'd0, sexp});
    chk((seen > 0) == valid, "R8 request only for valid command", seen, {31'd0, valid});
    if (valid) chk(seen == lat + 1, "R5 request held until response", seen, lat + 1);
    @(negedge clk);
    chk(nib_oe && nib_out == sexp, "R6 status held", {27'd0, nib_oe, nib_out}, {27'd0, 1'b1, sexp});
    sync_n = 1'b1;
    if (valid && !we && !be)
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        chk(nib_oe && nib_out == rexp[i*4 +: 4], "R7 read nibble", {27'd0, nib_oe, nib_out}, {27'd0, 1'b1, rexp[i*4 +: 4]});
      end
    @(negedge clk);
    chk(!nib_oe && !mem_req, "R11 bus released", {30'd0, nib_oe, mem_req}, 32'd0);
  endtask

  task automatic quiet(input string tag, input int cycles);
    bit bad;
    bad = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (nib_oe || mem_req) bad = 1'b1;
    end
    chk(!bad, tag, {31'd0, bad}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    mode_sel = 1'b0;
    repeat (3) @(negedge clk);
    mon_rst_n = 1'b1;
    mode_sel = 1'b1;
    send_head(4'h0, 4'b1000);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); nib_in = 4'h3;
    end
    @(negedge clk); sync_n = 1'b1;
    quiet("R1 monitor disabled when mode low at reset release", 20);

    @(negedge clk); mon_rst_n = 1'b0; mode_sel = 1'b1;
    repeat (3) @(negedge clk);
    mon_rst_n = 1'b1;
    mode_sel = 1'b0;
    @(negedge clk);
    chk(!nib_oe && !mem_req, "R11 reset state", {30'd0, nib_oe, mem_req}, 32'd0);

    run(4'h0, 4'b1010, 32'h8765_4321, 32'h0, 1);

    send_head(4'h0, 4'b1110);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); nib_in = 4'hA;
    end
    @(negedge clk); sync_n = 1'b1;
    quiet("R10 aborted frame makes no request", 12);
    run(4'h0, 4'b1101, 32'h0000_0FF0, 32'h0000_BEEF, 0);

    run(4'h5, 4'b1010, 32'h1111_2222, 32'h0, 0);
    run(4'h8, 4'b1100, 32'h3333_4444, 32'h0, 0);

    for (int c = 0; c < 16; c++) begin
      run(4'h0, 4'(c), 32'h1234_5678 + 32'(c) * 32'h0101_0101,
          32'hA5C3_0F69 ^ (32'(c) * 32'h1357_9BDF), c % 4);
      run(4'h0, 4'(c), 32'hE000_0000 | (32'(c) << 4), 32'h9ABC_DEF0, (c + 2) % 4);
    end

    mem_rdata = 32'hFFFF_FFFF;
    run(4'h0, 4'b1000, 32'h0000_0000, 32'h0, 3);
    run(4'h0, 4'b1101, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule